// File: doc/BRIEF.md
# Four-Phase Output Pattern Sequencer

This block is a small Moore controller that walks endlessly through four phases and drives a 4-bit word from the phase it is in. The word follows the fixed cycle 0001, 0011, 1100, 1000, one pattern per clock cycle while the advance enable is high. It can drive a row of four indicator lights or the four coil-select lines of a stepper driver stage. Step rate, direction and coil current are set outside the block.

The phase is held in a 2-bit register. There are four named phases: PH_A (00), PH_B (01), PH_C (10) and PH_D (11). There are four named transitions, all taken only when the advance enable is high: T_AB from PH_A to PH_B, T_BC from PH_B to PH_C, T_CD from PH_C to PH_D, and T_DA from PH_D back to PH_A. When the enable is low, each phase loops on itself. A synchronous active-high reset forces PH_A. The output word is decoded from the phase alone and can be re-registered, depending on a parameter. Both variants change the output only at a rising clock edge and have the same cycle timing.

Top module: `phase_seq`

## Requirements
- R1: The output word is ordered {w,x,y,z} with w at bit 3 and z at bit 0. It is 0001 in PH_A, 0011 in PH_B, 1100 in PH_C and 1000 in PH_D. With enable held high, the visible words cycle 0001, 0011, 1100, 1000 and then start again at 0001.
- R2: With the enable high, the word changes on every rising clock edge, so each pattern is visible for exactly one clock cycle.
- R3: Only the four listed patterns ever appear on the output after reset, and bits x and y are never both high.
- R4: When reset is sampled high at a rising edge, the word is 0001 (PH_A) from that edge onward. This holds whatever the enable level is.
- R5: When the enable is sampled low at a rising edge, the word after that edge equals the word before it.
- R6: After a hold, raising the enable again continues the sequence from the held pattern. The sequence does not restart at 0001.
- R7: The word only changes at a rising clock edge. Its value sampled at two points inside the same clock period is the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high, forces PH_A |
| adv_en | input | 1 | Advance enable; high steps one phase per edge, low holds |
| pat_o | output | 4 | Pattern word {w,x,y,z} |

## Verification
Every result of this block is due at the first rising edge after its stimulus is sampled. An enable or reset value applied between edges shows up on pat_o just after the next edge, with no extra latency in either output variant. For each cycle, the driver queues the one word that must appear after the coming edge. The monitor samples pat_o 2 ns after that edge and compares it with the head of the queue, so every comparison falls inside the cycle its stimulus targets. For R7, the monitor samples the word a second time, later in the same period, and checks that it has not moved.

// File: rtl/phase_seq_pkg.sv
package phase_seq_pkg;

    localparam int PHASE_W = 2;
    localparam int WORD_W  = 4;

    typedef enum logic [PHASE_W-1:0] {
        PH_A = 2'b00,
        PH_B = 2'b01,
        PH_C = 2'b10,
        PH_D = 2'b11
    } phase_t;

endpackage

// File: rtl/phase_seq_next.sv
module phase_seq_next
    import phase_seq_pkg::*;
(
    input  phase_t cur_i,
    input  logic   adv_i,
    output phase_t nxt_o
);

    always_comb begin
        nxt_o = cur_i;
        if (adv_i) begin
            unique case (cur_i)
                PH_A: nxt_o = PH_B;   // T_AB
                PH_B: nxt_o = PH_C;   // T_BC
                PH_C: nxt_o = PH_D;   // T_CD
                PH_D: nxt_o = PH_A;   // T_DA
            endcase
        end
    end

endmodule

// File: rtl/phase_seq_decode.sv
module phase_seq_decode
    import phase_seq_pkg::*;
(
    input  phase_t              ph_i,
    output logic [WORD_W-1:0]   word_o
);

    logic hi_bit;
    logic lo_bit;

    assign hi_bit = ph_i[1];
    assign lo_bit = ph_i[0];

    always_comb begin
        word_o[3] = hi_bit;
        word_o[2] = hi_bit & ~lo_bit;
        word_o[1] = ~hi_bit & lo_bit;
        word_o[0] = ~hi_bit;
    end

endmodule

// File: rtl/phase_seq.sv
module phase_seq
    import phase_seq_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              adv_en,
    output logic [WORD_W-1:0] pat_o
);

    localparam logic [WORD_W-1:0] RESET_WORD = 4'b0001;

    phase_t ph_q;
    phase_t ph_d;

    phase_seq_next u_next (
        .cur_i (ph_q),
        .adv_i (adv_en),
        .nxt_o (ph_d)
    );

    always_ff @(posedge clk) begin
        if (rst) ph_q <= PH_A;
        else     ph_q <= ph_d;
    end

    generate
        if (REG_OUT) begin : g_reg_out
            logic [WORD_W-1:0] word_d;
            logic [WORD_W-1:0] word_q;

            phase_seq_decode u_dec (
                .ph_i   (ph_d),
                .word_o (word_d)
            );

            always_ff @(posedge clk) begin
                if (rst) word_q <= RESET_WORD;
                else     word_q <= word_d;
            end

            assign pat_o = word_q;
        end else begin : g_comb_out
            phase_seq_decode u_dec (
                .ph_i   (ph_q),
                .word_o (pat_o)
            );
        end
    endgenerate

    assert_reset_word_R4: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pat_o == RESET_WORD));

    assert_hold_when_idle_R5: assert property (@(posedge clk) disable iff (rst)
        !adv_en |=> $stable(pat_o));

    assert_legal_word_R3: assert property (@(posedge clk) disable iff (rst)
        (pat_o == 4'b0001) || (pat_o == 4'b0011) ||
        (pat_o == 4'b1100) || (pat_o == 4'b1000));

    assert_xy_exclusive_R3: assert property (@(posedge clk) disable iff (rst)
        $countones(pat_o[2:1]) <= 1);

    assert_step_a_b_R1: assert property (@(posedge clk) disable iff (rst)
        (adv_en && pat_o == 4'b0001) |=> (pat_o == 4'b0011));

    assert_step_b_c_R1: assert property (@(posedge clk) disable iff (rst)
        (adv_en && pat_o == 4'b0011) |=> (pat_o == 4'b1100));

    assert_step_c_d_R1: assert property (@(posedge clk) disable iff (rst)
        (adv_en && pat_o == 4'b1100) |=> (pat_o == 4'b1000));

    assert_step_d_a_R1: assert property (@(posedge clk) disable iff (rst)
        (adv_en && pat_o == 4'b1000) |=> (pat_o == 4'b0001));

    assert_moves_each_edge_R2: assert property (@(posedge clk) disable iff (rst)
        adv_en |=> !$stable(pat_o));

endmodule

// File: tb/phase_seq_test.sv
module phase_seq_test;

    typedef struct {
        logic [3:0] exp;
        string      tag;
    } item_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       adv_en = 1'b0;
    logic [3:0] pat_o;

    item_t sb[$];
    int    n_cmp = 0;
    int    n_bad = 0;
    int    ref_idx = 0;
    bit    done = 1'b0;

    always #5 clk = ~clk;

    phase_seq uut (
        .clk    (clk),
        .rst    (rst),
        .adv_en (adv_en),
        .pat_o  (pat_o)
    );

    function automatic logic [3:0] word_of(input int idx);
        case (idx)
            0:       return 4'b0001;
            1:       return 4'b0011;
            2:       return 4'b1100;
            default: return 4'b1000;
        endcase
    endfunction

    task automatic drive(input logic r, input logic en, input string tag);
        @(negedge clk);
        rst    = r;
        adv_en = en;
        if (r)       ref_idx = 0;
        else if (en) ref_idx = (ref_idx + 1) % 4;
        sb.push_back('{exp: word_of(ref_idx), tag: tag});
    endtask

    initial begin : monitor
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() != 0) begin
                item_t it;
                logic [3:0] early;
                it = sb.pop_front();
                early = pat_o;
                n_cmp++;
                if (pat_o !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s: pat_o=%b expected=%b at %0t", it.tag, pat_o, it.exp, $time);
                end
                #2;
                n_cmp++;
                if (pat_o !== early) begin
                    n_bad++;
                    $display("FAIL R7: pat_o moved mid-cycle actual=%b expected=%b", pat_o, early);
                end
            end
        end
    end

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run hung actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : driver
        drive(1'b1, 1'b0, "R4 reset word");
        drive(1'b1, 1'b1, "R4 reset beats enable");
        for (int i = 0; i < 12; i++) drive(1'b0, 1'b1, "R1 R2 sequence");
        for (int i = 0; i < 3; i++)  drive(1'b0, 1'b0, "R5 hold");
        for (int i = 0; i < 2; i++)  drive(1'b0, 1'b1, "R6 resume");
        for (int i = 0; i < 2; i++)  drive(1'b0, 1'b0, "R5 hold mid-run");
        drive(1'b0, 1'b1, "R6 resume");
        drive(1'b1, 1'b0, "R4 reset while idle");
        for (int i = 0; i < 5; i++)  drive(1'b0, 1'b1, "R1 R3 after reset");
        drive(1'b1, 1'b1, "R4 reset while running");
        for (int i = 0; i < 4; i++)  drive(1'b0, 1'b1, "R2 one cycle each");
        @(negedge clk);
        adv_en = 1'b0;
        @(posedge clk);
        #6;
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule